// File: doc/BRIEF.md
# Ring-Buffer Drain Controller

This block empties a circular buffer held in memory, one 128-bit quadword at a time, into one of two output FIFOs. Software starts it with a tag pointer. The block then fetches tags through a small request/valid port. Each tag carries an identifier, a quadword count, a data address and an end flag. The block reads that many quadwords from memory and writes each one to the output that the two-bit target code selects.

Every tag pointer, and the data address of tags that live inside the ring, is folded into the ring region as `ring_base | (addr & ring_mask)`. The block compares its tag pointer with the address the producer is currently writing to. When the two are equal, the ring holds no unread tag. The block then stops fetching and signals an empty event.

Completion and empty events appear as one-cycle pulses. They also set a sticky status that software clears by writing ones.

Top module: `rdrain_ctrl`

## Requirements
- R1: After reset, `run`, `tag_req`, `mem_rd`, both output write strobes, `irq_pulse` and `irq_stat` are all 0.
- R2: Target code 2 selects output A and code 3 selects output B. Codes 0 (none) and 1 (illegal) issue no memory read and no output write while they are applied. The transfer stays pending and resumes once a legal target is applied.
- R3: A `go` pulse while idle loads the tag pointer with the folded `go_tadr`. Each accepted tag advances the pointer to fold(pointer + 16).
- R4: Tags with ID 1, 2 or 7 take fold(`tag_addr`) as their memory address. Every other ID reads from `tag_addr` unchanged.
- R5: Each quadword moved reads memory at the current address and writes the read data to the selected output in the same cycle. It then adds 16 to the address and subtracts one from the count. A tag moves exactly `tag_qwc` quadwords, so a count of 0 moves none.
- R6: While the selected output reports full, no read and no write occur, and no data is lost.
- R7: When the count is 0 and the tag's end flag is set, `run` falls. In the same cycle, a single-cycle pulse appears on `irq_pulse[0]` for output A or on `irq_pulse[1]` for output B.
- R8: When the count is 0, the end flag is clear and the tag ID is 1, the tag pointer is loaded with fold(final memory address).
- R9: While waiting for a tag with `tag_ptr == prod_addr`, `tag_req` stays low. `irq_pulse[2]` pulses once per such match.
- R10: Each `irq_stat` bit is set on the cycle after its pulse and cleared by a 1 on the matching `clr_w1c` bit. A set and a clear in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_sel | input | 2 | Drain target code (0 none, 1 illegal, 2 A, 3 B) |
| ring_base | input | AW | Ring region base |
| ring_mask | input | AW | Ring size mask |
| prod_addr | input | AW | Producer's current write address |
| go | input | 1 | Start pulse, honoured when idle |
| go_tadr | input | AW | Initial tag pointer |
| tag_req | output | 1 | Tag wanted at `tag_ptr` |
| tag_ptr | output | AW | Current tag pointer |
| tag_vld | input | 1 | Tag fields valid (accepted with `tag_req`) |
| tag_id | input | 3 | Tag identifier |
| tag_qwc | input | QCW | Quadword count |
| tag_addr | input | AW | Data address |
| tag_end | input | 1 | End flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, same cycle |
| outa_wr | output | 1 | Output A write strobe |
| outa_data | output | DW | Output A data |
| outa_full | input | 1 | Output A full |
| outb_wr | output | 1 | Output B write strobe |
| outb_data | output | DW | Output B data |
| outb_full | input | 1 | Output B full |
| run | output | 1 | Busy flag |
| irq_pulse | output | 3 | Event pulses: [0] A done, [1] B done, [2] ring empty |
| irq_stat | output | 3 | Sticky event status |
| clr_w1c | input | 3 | Write-one-to-clear for `irq_stat` |

## Verification
A completion pulse can land in the same cycle as software's write-one-to-clear on that same status bit. The bench provokes this by holding `clr_w1c[0]` high through the whole of an end-tagged transfer to output A. The bit must read 1 on the cycle after the pulse, because the set wins. It must read 0 one cycle later, because the clear is still held. A second overlap places a by-reference-pointer reload (R8) in the cycle that makes the tag pointer equal to the producer address. It is judged by a low `tag_req`, the reloaded pointer and exactly one empty pulse.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE} rdc_state_e;
   typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_BAD = 2'd1, TGT_A = 2'd2, TGT_B = 2'd3} rdc_tgt_e;
   localparam int IRQ_N     = 3;
   localparam int IRQ_DONEA = 0;
   localparam int IRQ_DONEB = 1;
   localparam int IRQ_EMPTY = 2;
   localparam int QW_BYTES  = 16;
endpackage

// File: rtl/rdc_ring_fold.sv
module rdc_ring_fold #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] mask,
   output logic [AW-1:0] addr_out
);
   assign addr_out = base | (addr_in & mask);
endmodule

// File: rtl/rdc_target_sel.sv
module rdc_target_sel
   import rdc_pkg::*;
(
   input  logic [1:0] tgt_sel,
   input  logic       a_full,
   input  logic       b_full,
   output logic       live,
   output logic       pick_b,
   output logic       full
);
   always_comb begin
      live   = 1'b0;
      pick_b = 1'b0;
      full   = 1'b0;
      unique case (rdc_tgt_e'(tgt_sel))
         TGT_A: begin live = 1'b1; full = a_full; end
         TGT_B: begin live = 1'b1; pick_b = 1'b1; full = b_full; end
         default: ;
      endcase
   end
endmodule

// File: rtl/rdc_irq_bank.sv
module rdc_irq_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   for (genvar k = 0; k < N; k++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) stat_o[k] <= 1'b0;
         else        stat_o[k] <= (stat_o[k] & ~clr_i[k]) | set_i[k];
      end
   end
endmodule

// File: rtl/rdc_engine.sv
module rdc_engine
   import rdc_pkg::*;
#(
   parameter int AW  = 32,
   parameter int QCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [AW-1:0]  go_fold,
   input  logic [AW-1:0]  prod_addr,
   input  logic           tag_vld,
   input  logic [2:0]     tag_id,
   input  logic [QCW-1:0] tag_qwc,
   input  logic [AW-1:0]  tag_addr,
   input  logic [AW-1:0]  tag_addr_fold,
   input  logic           tag_end,
   input  logic [AW-1:0]  tnext_fold,
   input  logic [AW-1:0]  madr_fold,
   input  logic           tgt_live,
   input  logic           tgt_full,
   input  logic           tgt_b,
   output logic [AW-1:0]  tadr,
   output logic [AW-1:0]  madr,
   output logic           tag_req,
   output logic           mem_rd,
   output logic           run,
   output logic [IRQ_N-1:0] pulse
);
   localparam logic [AW-1:0]  STEP = AW'(QW_BYTES);
   localparam logic [QCW-1:0] ONE  = QCW'(1);

   rdc_state_e     state;
   logic [QCW-1:0] qwc;
   logic [2:0]     id_q;
   logic           end_q;
   logic           emp_seen;
   logic           at_prod;
   logic           in_ring;

   assign at_prod = (tadr == prod_addr);
   assign in_ring = (tag_id == 3'd1) || (tag_id == 3'd2) || (tag_id == 3'd7);
   assign tag_req = (state == ST_FETCH) && !at_prod;
   assign mem_rd  = (state == ST_MOVE) && (qwc != '0) && tgt_live && !tgt_full;
   assign run     = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tadr     <= '0;
         madr     <= '0;
         qwc      <= '0;
         id_q     <= '0;
         end_q    <= 1'b0;
         emp_seen <= 1'b0;
         pulse    <= '0;
      end else begin
         pulse <= '0;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  tadr     <= go_fold;
                  emp_seen <= 1'b0;
                  state    <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (at_prod) begin
                  if (!emp_seen) begin
                     pulse[IRQ_EMPTY] <= 1'b1;
                     emp_seen         <= 1'b1;
                  end
               end else begin
                  emp_seen <= 1'b0;
                  if (tag_vld) begin
                     qwc   <= tag_qwc;
                     id_q  <= tag_id;
                     end_q <= tag_end;
                     madr  <= in_ring ? tag_addr_fold : tag_addr;
                     tadr  <= tnext_fold;
                     state <= ST_MOVE;
                  end
               end
            end
            ST_MOVE: begin
               if (qwc != '0) begin
                  if (mem_rd) begin
                     madr <= madr + STEP;
                     qwc  <= qwc - ONE;
                  end
               end else if (end_q) begin
                  pulse[IRQ_DONEA] <= tgt_live && !tgt_b;
                  pulse[IRQ_DONEB] <= tgt_live && tgt_b;
                  state            <= ST_IDLE;
               end else begin
                  if (id_q == 3'd1) tadr <= madr_fold;
                  emp_seen <= 1'b0;
                  state    <= ST_FETCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rdrain_ctrl.sv
module rdrain_ctrl
   import rdc_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 128,
   parameter int QCW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       tgt_sel,
   input  logic [AW-1:0]    ring_base,
   input  logic [AW-1:0]    ring_mask,
   input  logic [AW-1:0]    prod_addr,
   input  logic             go,
   input  logic [AW-1:0]    go_tadr,
   output logic             tag_req,
   output logic [AW-1:0]    tag_ptr,
   input  logic             tag_vld,
   input  logic [2:0]       tag_id,
   input  logic [QCW-1:0]   tag_qwc,
   input  logic [AW-1:0]    tag_addr,
   input  logic             tag_end,
   output logic             mem_rd,
   output logic [AW-1:0]    mem_addr,
   input  logic [DW-1:0]    mem_rdata,
   output logic             outa_wr,
   output logic [DW-1:0]    outa_data,
   input  logic             outa_full,
   output logic             outb_wr,
   output logic [DW-1:0]    outb_data,
   input  logic             outb_full,
   output logic             run,
   output logic [IRQ_N-1:0] irq_pulse,
   output logic [IRQ_N-1:0] irq_stat,
   input  logic [IRQ_N-1:0] clr_w1c
);
   if (AW < 8)  begin : g_bad_aw  $error("AW must be at least 8");  end
   if (DW < 32) begin : g_bad_dw  $error("DW must be at least 32"); end
   if (QCW < 1) begin : g_bad_qcw $error("QCW must be positive");   end

   localparam logic [AW-1:0] STEP = AW'(QW_BYTES);

   logic [AW-1:0] tadr, madr, go_fold, tnext_fold, taddr_fold, madr_fold;
   logic          tgt_live, tgt_full, tgt_b;

   rdc_ring_fold #(.AW(AW)) u_fold_go (.addr_in(go_tadr),     .base(ring_base), .mask(ring_mask), .addr_out(go_fold));
   rdc_ring_fold #(.AW(AW)) u_fold_tn (.addr_in(tadr + STEP), .base(ring_base), .mask(ring_mask), .addr_out(tnext_fold));
   rdc_ring_fold #(.AW(AW)) u_fold_ta (.addr_in(tag_addr),    .base(ring_base), .mask(ring_mask), .addr_out(taddr_fold));
   rdc_ring_fold #(.AW(AW)) u_fold_ma (.addr_in(madr),        .base(ring_base), .mask(ring_mask), .addr_out(madr_fold));

   rdc_target_sel u_tsel (
      .tgt_sel(tgt_sel), .a_full(outa_full), .b_full(outb_full),
      .live(tgt_live), .pick_b(tgt_b), .full(tgt_full)
   );

   rdc_engine #(.AW(AW), .QCW(QCW)) u_eng (
      .clk(clk), .rst_n(rst_n), .go(go), .go_fold(go_fold), .prod_addr(prod_addr),
      .tag_vld(tag_vld), .tag_id(tag_id), .tag_qwc(tag_qwc), .tag_addr(tag_addr),
      .tag_addr_fold(taddr_fold), .tag_end(tag_end), .tnext_fold(tnext_fold),
      .madr_fold(madr_fold), .tgt_live(tgt_live), .tgt_full(tgt_full), .tgt_b(tgt_b),
      .tadr(tadr), .madr(madr), .tag_req(tag_req), .mem_rd(mem_rd), .run(run),
      .pulse(irq_pulse)
   );

   rdc_irq_bank #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(irq_pulse), .clr_i(clr_w1c), .stat_o(irq_stat)
   );

   assign tag_ptr   = tadr;
   assign mem_addr  = madr;
   assign outa_wr   = mem_rd && !tgt_b;
   assign outb_wr   = mem_rd && tgt_b;
   assign outa_data = mem_rdata;
   assign outb_data = mem_rdata;
endmodule

// File: rtl/rdc_checks.sv
module rdc_checks (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] tgt_sel,
   input logic       outa_full,
   input logic       outb_full,
   input logic       mem_rd,
   input logic       outa_wr,
   input logic       outb_wr,
   input logic       tag_req,
   input logic       run,
   input logic [2:0] irq_pulse,
   input logic [2:0] irq_stat
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!mem_rd && !tag_req));
   a_r2_no_target_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel < 2'd2) |-> !mem_rd);
   a_r5_read_feeds_one_output: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({outa_wr, outb_wr}) == int'(mem_rd));
   a_r6_stall_a: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel == 2'd2 && outa_full) |-> !mem_rd);
   a_r6_stall_b: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel == 2'd3 && outb_full) |-> !mem_rd);
   a_r7_done_a_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[0] |=> !irq_pulse[0]);
   a_r7_done_b_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[1] |=> !irq_pulse[1]);
   a_r9_empty_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[2] |=> !irq_pulse[2]);
   a_r10_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[0] |=> irq_stat[0]);
   a_r10_sticky_empty: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[2] |=> irq_stat[2]);
endmodule

bind rdrain_ctrl rdc_checks u_rdc_checks (
   .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .outa_full(outa_full), .outb_full(outb_full),
   .mem_rd(mem_rd), .outa_wr(outa_wr), .outb_wr(outb_wr), .tag_req(tag_req), .run(run),
   .irq_pulse(irq_pulse), .irq_stat(irq_stat)
);

// File: tb/rdrain_ctrl_bench.sv
`timescale 1ns/1ps
module rdrain_ctrl_bench;
   localparam int AW = 32, DW = 128, QCW = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, go, tag_vld, tag_end, outa_full, outb_full;
   logic [1:0] tgt_sel;
   logic [AW-1:0] ring_base, ring_mask, prod_addr, go_tadr, tag_addr;
   logic [2:0] tag_id, clr_w1c;
   logic [QCW-1:0] tag_qwc;
   logic tag_req, mem_rd, outa_wr, outb_wr, run;
   logic [AW-1:0] tag_ptr, mem_addr;
   logic [DW-1:0] mem_rdata, outa_data, outb_data;
   logic [2:0] irq_pulse, irq_stat;

   rdrain_ctrl #(.AW(AW), .DW(DW), .QCW(QCW)) u_rdrain_ctrl (.*);

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {4{a ^ 32'h5A5A_0000}};
   endfunction
   assign mem_rdata = pat(mem_addr);

   int checks = 0, errors = 0;
   int wa = 0, wb = 0, derr = 0, np0 = 0, np1 = 0, np2 = 0;
   logic [AW-1:0] exp_next = '0;

   always @(posedge clk) begin
      if (outa_wr) begin wa++; if (outa_data != pat(exp_next)) derr++; exp_next += 32'd16; end
      if (outb_wr) begin wb++; if (outb_data != pat(exp_next)) derr++; exp_next += 32'd16; end
      if (rst_n && irq_pulse[0]) np0++;
      if (rst_n && irq_pulse[1]) np1++;
      if (rst_n && irq_pulse[2]) np2++;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      wa = 0; wb = 0; derr = 0; np0 = 0; np1 = 0; np2 = 0;
   endtask

   task automatic start(input logic [AW-1:0] t);
      @(negedge clk); go = 1'b1; go_tadr = t;
      @(negedge clk); go = 1'b0;
   endtask

   task automatic give_tag(input logic [2:0] id, input logic [QCW-1:0] q,
                           input logic [AW-1:0] a, input logic e);
      int n = 0;
      while (!tag_req && n < 200) begin @(negedge clk); n++; end
      tag_vld = 1'b1; tag_id = id; tag_qwc = q; tag_addr = a; tag_end = e;
      @(negedge clk); tag_vld = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (run && n < 500) begin @(negedge clk); n++; end
   endtask

   task automatic finish_up();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   // {tgt[1:0], id[2:0], qwc[7:0], addr[31:0], expected first read address[31:0]}
   localparam int NV = 5;
   localparam logic [76:0] VEC [NV] = '{
      {2'd2, 3'd2, 8'd3, 32'h0000_05F0, 32'h0000_15F0},
      {2'd3, 3'd7, 8'd2, 32'h0000_3FF0, 32'h0000_1FF0},
      {2'd2, 3'd3, 8'd2, 32'h0000_05F0, 32'h0000_05F0},
      {2'd3, 3'd0, 8'd1, 32'h0000_8000, 32'h0000_8000},
      {2'd2, 3'd1, 8'd0, 32'h0000_0040, 32'h0000_1040}
   };

   initial begin
      rst_n = 1'b0; go = 1'b0; tag_vld = 1'b0; tag_end = 1'b0; outa_full = 1'b0; outb_full = 1'b0;
      tgt_sel = 2'd2; ring_base = 32'h0000_1000; ring_mask = 32'h0000_0FF0;
      prod_addr = 32'hFFFF_0000; go_tadr = '0; tag_addr = '0; tag_id = '0; clr_w1c = '0; tag_qwc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 run", run, 0);
      chk("R1 tag_req", tag_req, 0);
      chk("R1 mem_rd", mem_rd, 0);
      chk("R1 irq_stat", irq_stat, 0);
      chk("R1 irq_pulse", irq_pulse, 0);

      // Table walk: R3 R4 R5 R7
      for (int i = 0; i < NV; i++) begin
         logic [76:0] v = VEC[i];
         clear_counts();
         clr_w1c = 3'b111; @(negedge clk); clr_w1c = '0;
         tgt_sel = v[76:75];
         exp_next = v[31:0];
         start(32'h0000_1FF0);
         chk("R3 fold go pointer", tag_ptr, 32'h0000_1FF0);
         give_tag(v[74:72], QCW'(v[71:64]), v[63:32], 1'b1);
         chk("R3 pointer advance wraps", tag_ptr, 32'h0000_1000);
         wait_idle();
         @(negedge clk);
         chk("R5 quadwords on selected output", (v[76:75] == 2'd2) ? wa : wb, 64'(v[71:64]));
         chk("R2 no writes on other output", (v[76:75] == 2'd2) ? wb : wa, 0);
         chk("R4 R5 data and address sequence", derr, 0);
         chk("R7 done status", irq_stat[1:0], (v[76:75] == 2'd2) ? 2'b01 : 2'b10);
         chk("R7 single pulse", np0 + np1, 1);
      end

      // R6 stall on full
      clear_counts(); tgt_sel = 2'd2; outa_full = 1'b1; exp_next = 32'h0000_1100;
      start(32'h0000_1200);
      give_tag(3'd2, 16'd4, 32'h0000_0100, 1'b1);
      repeat (5) @(negedge clk);
      chk("R6 no read while full", mem_rd, 0);
      chk("R6 no write while full", wa, 0);
      outa_full = 1'b0;
      wait_idle(); @(negedge clk);
      chk("R6 all data after release", wa, 4);
      chk("R6 data intact", derr, 0);

      // R2 none and illegal targets
      clear_counts(); tgt_sel = 2'd0; exp_next = 32'h0000_1300;
      start(32'h0000_1200);
      give_tag(3'd2, 16'd2, 32'h0000_0300, 1'b1);
      repeat (4) @(negedge clk);
      chk("R2 code 0 issues no read", wa + wb, 0);
      tgt_sel = 2'd1; #1;
      chk("R2 code 1 no read strobe", mem_rd, 0);
      repeat (4) @(negedge clk);
      chk("R2 code 1 issues no read", wa + wb, 0);
      chk("R2 transfer pending", run, 1);
      tgt_sel = 2'd3;
      wait_idle(); @(negedge clk);
      chk("R2 resumes on output B", wb, 2);

      // R8 pointer reload meets R9 empty in the same step
      clear_counts(); tgt_sel = 2'd2; exp_next = 32'h0000_1FC0;
      clr_w1c = 3'b111; @(negedge clk); clr_w1c = '0;
      start(32'h0000_1FF0);
      prod_addr = 32'h0000_1FE0;
      give_tag(3'd1, 16'd2, 32'h0000_1FC0, 1'b0);
      repeat (6) @(negedge clk);
      chk("R8 pointer reloaded from address", tag_ptr, 32'h0000_1FE0);
      chk("R9 no tag request at producer", tag_req, 0);
      chk("R9 empty status", irq_stat[2], 1);
      chk("R9 one empty pulse", np2, 1);
      prod_addr = 32'hFFFF_0000; #1;
      chk("R9 request resumes", tag_req, 1);
      // R10 clear
      clr_w1c = 3'b100; @(negedge clk); clr_w1c = '0;
      chk("R10 write one clears", irq_stat[2], 0);
      // R10 set wins over simultaneous clear
      clr_w1c = 3'b001;
      give_tag(3'd2, 16'd1, 32'h0000_0000, 1'b1);
      exp_next = 32'h0000_1000;
      wait_idle();
      chk("R7 pulse with run low", irq_pulse[0], 1);
      @(negedge clk);
      chk("R10 set beats clear", irq_stat[0], 1);
      @(negedge clk);
      chk("R10 held clear takes effect", irq_stat[0], 0);
      clr_w1c = '0;
      finish_up();
   end
endmodule